// File: doc/BRIEF.md
# CPU Status Register with Power-Down and Time-Out Flags

This block is the 8-bit status register of a small microcontroller core. It holds five kinds of state:

- the three arithmetic flags (carry, digit carry and zero);
- a page select bit that switches a group of control registers between two pages;
- two read-only, active-low detector indications;
- a power-down flag and a time-out flag.

The two flags in the last item record why the core last reset or woke up.

The ALU updates the arithmetic flags through a per-flag write mask. The CPU writes the register as a whole byte, but only the arithmetic flags and the page bit accept that data.

The power-down and time-out flags change only on system events:

- the sleep instruction;
- the watchdog-clear instruction;
- a watchdog time-out;
- the external reset pin;
- power-on reset.

Each event is qualified by whether the core is asleep. This lets firmware tell apart a watchdog wake-up, a watchdog reset in normal running, a reset-pin wake-up and a cold power-up.

Top module: `stat_reg`

## Requirements
- R1: While `rst_ni` is low (power-on), the time-out flag (bit 4) and the power-down flag (bit 3) are 1. Carry, digit carry, zero and page are 0. The detector bits read 1.
- R2: `status_o` has this layout: bit 0 carry, bit 1 digit carry, bit 2 zero, bit 3 power-down, bit 4 time-out, bit 5 detector A, bit 6 page, bit 7 detector B. `page_o` always equals bit 6.
- R3: For each flag i (0 = carry, 1 = digit carry, 2 = zero), `alu_we_i[i]` high loads `alu_flags_i[i]` into that flag at the next clock edge. Flags whose enable is low are not affected by the ALU.
- R4: A CPU write (`cpu_we_i`) loads `cpu_wdata_i` bits 0, 1, 2 and 6 into carry, digit carry, zero and page. The write data in bits 3, 4, 5 and 7 has no effect.
- R5: When an ALU enable and a CPU write hit the same flag in one cycle, the ALU value is stored.
- R6: The sleep strobe alone sets time-out to 1 and power-down to 0.
- R7: The watchdog-clear strobe sets time-out to 1 and power-down to 1.
- R8: A watchdog time-out sets time-out to 0. Power-down becomes 0 if `sleeping_i` is high and 1 otherwise.
- R9: A pulse on `ext_rst_i` while sleeping gives time-out 1 and power-down 0. While not sleeping it leaves both flags unchanged, as does a cycle with no event.
- R10: When several events occur in one cycle, the priority is: watchdog time-out, then external reset while sleeping, then watchdog clear, then sleep strobe.
- R11: Status bit 5 shows `det_n_i[0]` and bit 7 shows `det_n_i[1]` (0 = signal valid) after `SYNC_STAGES` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| alu_we_i | input | 3 | Per-flag ALU update enable (bit0 C, bit1 DC, bit2 Z) |
| alu_flags_i | input | 3 | ALU flag values |
| cpu_we_i | input | 1 | CPU write strobe to the status register |
| cpu_wdata_i | input | 8 | CPU write data |
| sleep_cmd_i | input | 1 | Sleep instruction strobe |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| wdt_to_i | input | 1 | Watchdog time-out event |
| ext_rst_i | input | 1 | External reset pin pulse (synchronous strobe) |
| sleeping_i | input | 1 | Core is in sleep mode |
| det_n_i | input | 2 | Raw active-low detector indications (bit0 A, bit1 B) |
| status_o | output | 8 | Status register value |
| page_o | output | 1 | Control-register page select |

## Verification
The event logic is swept exhaustively. All 32 combinations of time-out, reset pin, sleep state, watchdog-clear and sleep strobe are applied from each of the four prior time-out/power-down states. This separates the four wake and reset causes and shows that every priority pair resolves correctly. The flag path is swept over all 2048 combinations of ALU enable mask, ALU values, CPU write strobe and the four writable data bits. The other write-data bits take pseudo-random values. These cases tell masked ALU updates, CPU-only writes and ALU-over-CPU collisions apart. They also show that the read-only and event bits ignore write data. Each detector input value is checked one edge before and at the end of its synchronizer latency.

// File: rtl/stat_pkg.sv
`timescale 1ns/1ps
package stat_pkg;
  localparam int unsigned N_ARITH = 3;
  localparam int unsigned BIT_C   = 0;
  localparam int unsigned BIT_DC  = 1;
  localparam int unsigned BIT_Z   = 2;
  localparam int unsigned BIT_P   = 3;
  localparam int unsigned BIT_T   = 4;
  localparam int unsigned BIT_DA  = 5;
  localparam int unsigned BIT_PG  = 6;
  localparam int unsigned BIT_DB  = 7;

  typedef struct packed {
    logic t;
    logic p;
  } pwr_flags_t;

  localparam pwr_flags_t PWR_COLD = '{t: 1'b1, p: 1'b1};
endpackage

// File: rtl/stat_pwr_flags.sv
`timescale 1ns/1ps
module stat_pwr_flags
  import stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_cmd_i,
  input  logic       wdt_clr_i,
  input  logic       wdt_to_i,
  input  logic       ext_rst_i,
  input  logic       sleeping_i,
  output pwr_flags_t flags_o
);
  pwr_flags_t cur_q, nxt;

  // lowest priority first, later assignments override
  always_comb begin
    nxt = cur_q;
    if (sleep_cmd_i)              nxt = '{t: 1'b1, p: 1'b0};
    if (wdt_clr_i)                nxt = '{t: 1'b1, p: 1'b1};
    if (ext_rst_i && sleeping_i)  nxt = '{t: 1'b1, p: 1'b0};
    if (wdt_to_i)                 nxt = '{t: 1'b0, p: ~sleeping_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= PWR_COLD;
    else         cur_q <= nxt;
  end

  assign flags_o = cur_q;
endmodule

// File: rtl/stat_arith_flags.sv
`timescale 1ns/1ps
module stat_arith_flags
  import stat_pkg::*;
#(
  parameter int unsigned NF = N_ARITH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] alu_we_i,
  input  logic [NF-1:0] alu_flags_i,
  input  logic          cpu_we_i,
  input  logic [NF-1:0] cpu_flags_i,
  input  logic          cpu_page_i,
  output logic [NF-1:0] flags_o,
  output logic          page_o
);
  logic [NF-1:0] flag_q;
  logic          page_q;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q[g] <= 1'b0;
      else if (alu_we_i[g]) flag_q[g] <= alu_flags_i[g];
      else if (cpu_we_i)    flag_q[g] <= cpu_flags_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       page_q <= 1'b0;
    else if (cpu_we_i) page_q <= cpu_page_i;
  end

  assign flags_o = flag_q;
  assign page_o  = page_q;
endmodule

// File: rtl/stat_det_sync.sv
`timescale 1ns/1ps
module stat_det_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [W-1:0] stg_q [STAGES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
      end else begin
        stg_q[0] <= d_i;
        for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
    end
    assign q_o = stg_q[STAGES-1];
  end
endmodule

// File: rtl/stat_reg.sv
`timescale 1ns/1ps
module stat_reg
  import stat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] alu_we_i,
  input  logic [2:0] alu_flags_i,
  input  logic       cpu_we_i,
  input  logic [7:0] cpu_wdata_i,
  input  logic       sleep_cmd_i,
  input  logic       wdt_clr_i,
  input  logic       wdt_to_i,
  input  logic       ext_rst_i,
  input  logic       sleeping_i,
  input  logic [1:0] det_n_i,
  output logic [7:0] status_o,
  output logic       page_o
);
  pwr_flags_t   pwr;
  logic [2:0]   arith;
  logic         page;
  logic [1:0]   det_n;

  stat_pwr_flags u_pwr (
    .clk_i, .rst_ni, .sleep_cmd_i, .wdt_clr_i, .wdt_to_i, .ext_rst_i, .sleeping_i,
    .flags_o (pwr)
  );

  stat_arith_flags #(.NF(N_ARITH)) u_arith (
    .clk_i, .rst_ni, .alu_we_i, .alu_flags_i, .cpu_we_i,
    .cpu_flags_i (cpu_wdata_i[BIT_Z:BIT_C]),
    .cpu_page_i  (cpu_wdata_i[BIT_PG]),
    .flags_o     (arith),
    .page_o      (page)
  );

  stat_det_sync #(.W(2), .STAGES(SYNC_STAGES)) u_det (
    .clk_i, .rst_ni, .d_i (det_n_i), .q_o (det_n)
  );

  always_comb begin
    status_o                = '0;
    status_o[BIT_Z:BIT_C]   = arith;
    status_o[BIT_P]         = pwr.p;
    status_o[BIT_T]         = pwr.t;
    status_o[BIT_DA]        = det_n[0];
    status_o[BIT_PG]        = page;
    status_o[BIT_DB]        = det_n[1];
  end

  assign page_o = page;
endmodule

// File: rtl/stat_reg_chk.sv
`timescale 1ns/1ps
module stat_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] alu_we_i,
  input logic [2:0] alu_flags_i,
  input logic       cpu_we_i,
  input logic [7:0] cpu_wdata_i,
  input logic       sleep_cmd_i,
  input logic       wdt_clr_i,
  input logic       wdt_to_i,
  input logic       ext_rst_i,
  input logic       sleeping_i,
  input logic [7:0] status_o
);
  logic ext_wake;
  assign ext_wake = ext_rst_i && sleeping_i;

  // R6
  sleep_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_cmd_i && !wdt_clr_i && !wdt_to_i && !ext_wake |=> status_o[4:3] == 2'b10);
  // R7
  wdt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i && !wdt_to_i && !ext_wake |=> status_o[4:3] == 2'b11);
  // R8
  wdt_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_i |=> status_o[4] == 1'b0 && status_o[3] == !$past(sleeping_i));
  // R9
  ext_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wake && !wdt_to_i |=> status_o[4:3] == 2'b10);
  // R9
  tp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_cmd_i && !wdt_clr_i && !wdt_to_i && !ext_wake |=> $stable(status_o[4:3]));
  // R5
  alu_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_we_i[0] |=> status_o[0] == $past(alu_flags_i[0]));
  // R4
  cpu_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && alu_we_i == 3'b000 |=>
      status_o[6] == $past(cpu_wdata_i[6]) && status_o[2:0] == $past(cpu_wdata_i[2:0]));
endmodule

bind stat_reg stat_reg_chk u_chk (.*);

// File: tb/sim_stat_reg.sv
`timescale 1ns/1ps
module sim_stat_reg;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] alu_we = '0, alu_flags = '0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic       sleep_cmd = 0, wdt_clr = 0, wdt_to = 0, ext_rst = 0, sleeping = 0;
  logic [1:0] det_n = 2'b11;
  logic [7:0] status;
  logic       page;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  stat_reg #(.SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni, .alu_we_i(alu_we), .alu_flags_i(alu_flags),
    .cpu_we_i(cpu_we), .cpu_wdata_i(cpu_wdata), .sleep_cmd_i(sleep_cmd),
    .wdt_clr_i(wdt_clr), .wdt_to_i(wdt_to), .ext_rst_i(ext_rst),
    .sleeping_i(sleeping), .det_n_i(det_n), .status_o(status), .page_o(page)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sleep_cmd = 0; wdt_clr = 0; wdt_to = 0; ext_rst = 0; sleeping = 0;
    alu_we = '0; cpu_we = 0;
  endtask

  // expected {t,p} from the event table and priority
  function automatic logic [1:0] tp_model(logic [1:0] cur, bit to, bit ext, bit sl, bit clr, bit slp);
    if (to)            return {1'b0, ~sl};
    if (ext && sl)     return 2'b10;
    if (clr)           return 2'b11;
    if (slp)           return 2'b10;
    return cur;
  endfunction

  initial begin
    logic [7:0] lfsr = 8'h5a;
    logic [3:0] fl;          // {page, z, dc, c}
    logic [1:0] tp;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    check(status == 8'hB8, "R1", status, 8'hB8);
    check(page == 1'b0, "R2", {7'd0, page}, 8'h00);

    // R6..R10 exhaustive event sweep from all prior states
    for (int init = 0; init < 4; init++) begin
      for (int c = 0; c < 32; c++) begin
        logic [1:0] exp_tp;
        string tag;
        idle();
        case (init)
          3: wdt_clr = 1;
          2: sleep_cmd = 1;
          1: wdt_to = 1;
          default: begin wdt_to = 1; sleeping = 1; end
        endcase
        tick();
        check(status[4:3] == 2'(init), "R8", {6'd0, status[4:3]}, 8'(init));
        idle();
        wdt_to = c[0]; ext_rst = c[1]; sleeping = c[2]; wdt_clr = c[3]; sleep_cmd = c[4];
        exp_tp = tp_model(2'(init), c[0], c[1], c[2], c[3], c[4]);
        if ($countones({c[0], c[1] & c[2], c[3], c[4]}) > 1) tag = "R10";
        else if (c[0])          tag = "R8";
        else if (c[1] && c[2])  tag = "R9";
        else if (c[3])          tag = "R7";
        else if (c[4])          tag = "R6";
        else                    tag = "R9";
        tick();
        check(status[4:3] == exp_tp, tag, {6'd0, status[4:3]}, {6'd0, exp_tp});
      end
    end

    // R3/R4/R5 flag sweep; leave T,P in a known state first
    idle(); wdt_clr = 1; tick(); idle();
    tp = 2'b11;
    fl = {status[6], status[2:0]};
    for (int i = 0; i < 2048; i++) begin
      string tag;
      logic [7:0] exp_s;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      alu_we = i[2:0]; alu_flags = i[5:3]; cpu_we = i[6];
      cpu_wdata = lfsr;
      cpu_wdata[2:0] = i[9:7];
      cpu_wdata[6] = i[10];
      for (int b = 0; b < 3; b++) begin
        if (alu_we[b])   fl[b] = alu_flags[b];
        else if (cpu_we) fl[b] = cpu_wdata[b];
      end
      if (cpu_we) fl[3] = cpu_wdata[6];
      if ((alu_we != 0) && cpu_we) tag = "R5";
      else if (cpu_we)             tag = "R4";
      else                         tag = "R3";
      exp_s = {1'b1, fl[3], 1'b1, tp, fl[2:0]};
      tick();
      check(status == exp_s, tag, status, exp_s);
      if (i % 64 == 0) check(page == status[6], "R2", {7'd0, page}, {7'd0, status[6]});
    end
    idle();

    // R11 detector bits with synchronizer latency
    for (int v = 0; v < 4; v++) begin
      logic [1:0] old;
      old = {status[7], status[5]};
      det_n = 2'(v);
      for (int k = 0; k < SYNC - 1; k++) tick();
      if (SYNC > 0) begin
        check({status[7], status[5]} == old, "R11", {6'd0, status[7], status[5]}, {6'd0, old});
        tick();
      end
      check({status[7], status[5]} == 2'(v), "R11", {6'd0, status[7], status[5]}, 8'(v));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule